// File: doc/BRIEF.md
# Calibrated Seconds Tick Generator

This block turns a slow crystal-rate strobe into a one-cycle pulse once per second. It counts crystal ticks (only while the oscillator enable is high) and ends each second when the count reaches a programmable whole-tick value. A second therefore lasts the whole-tick value plus one ticks. A fractional correction can lengthen some seconds by one tick each. Within a repeating cycle of sixteen seconds, the first N seconds are stretched, where N is a 4-bit field. This trims the average rate in steps of one sixteenth of a tick per second.

The calibration word is sampled only at the end of a second. Software may rewrite it at any time without disturbing the second in progress. The block is meant to sit between a crystal-clock synchronizer and a seconds counter. Its output strobe advances that counter.

Top module: `sec_tick_gen`

## Requirements
- R1: `calWord[15:0]` holds the whole-tick value W. With fractional correction disabled, every second lasts exactly W+1 counted ticks, for any W from 0 to 65535, regardless of how many idle cycles separate the ticks.
- R2: `secPulse` is high for exactly one clock cycle per completed second: the cycle after the clock edge that sampled the second's final tick. With W=0 and a tick on every cycle it is high on every cycle.
- R3: A tick is counted only when `oscEnable` is high at the same clock edge. Ticks presented while it is low are ignored: no pulse appears and the partial count is unchanged.
- R4: `calWord[20]` enables fractional correction and `calWord[19:16]` gives N. Seconds are numbered from 0 after reset, and the position within the cycle is the second's number mod 16. A second whose position is below N lasts W+2 ticks; any other second lasts W+1.
- R5: When `calWord[20]` is 0, the field `calWord[19:16]` has no effect on any second's length.
- R6: The calibration word present at the clock edge that completes a second governs the next second. Changes made during a second do not alter that second's length.
- R7: Reset clears the tick count and the sixteen-second position. It loads the active calibration with W=0x7FFF and correction disabled, so the first second after reset lasts 32768 ticks. `secPulse` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscEnable | input | 1 | Oscillator enable; ticks count only while high |
| xtalTick | input | 1 | One-cycle crystal tick strobe |
| calWord | input | 21 | Calibration: [15:0] whole ticks, [19:16] fraction N, [20] fraction enable |
| secPulse | output | 1 | One-cycle seconds strobe |

## Verification
The bench measures the length in ticks of every second and compares it with W+1, plus one when the second's position mod 16 is below an enabled N. It sweeps N over 0, 1, 7 and 15 across full sixteen-second cycles, so a stretch applied to the wrong seconds or counted from the wrong position shows up. Tick spacing changes from back-to-back to sparse, which separates counting ticks from counting clock cycles. A set but disabled fraction field, disabled-oscillator ticks and a word rewritten mid-second check that inputs which must be ignored really are. W=0, W=0xFFFF with a stretch, and the 32768-tick default second cover the edges of the counter width.

// File: rtl/sec_tick_pkg.sv
package sec_tick_pkg;

  // Strobes passed from the control to the tick datapath.
  typedef struct packed {
    logic count;    // a qualified tick arrives this cycle
    logic restart;  // the qualified tick completes the second
  } tickCmd_t;

endpackage

// File: rtl/sec_tick_dp.sv
module sec_tick_dp
  import sec_tick_pkg::*;
#(
  parameter int WHOLE_W = 16,
  localparam int CNT_W = WHOLE_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickCmd_t         cmd,
  input  logic [CNT_W-1:0] target,
  output logic             hitTarget
);

  logic [CNT_W-1:0] tickCount;

  // One extra bit lets a stretched second reach 2**WHOLE_W ticks.
  assign hitTarget = (tickCount == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (cmd.restart) begin
      tickCount <= '0;
    end else if (cmd.count) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  // R1: the count never runs past the end of the current second.
  a_r1_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= target);

  // R1: a completed second leaves the counter at zero.
  a_r1_restart_zero : assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (tickCount == '0));

  // R3: without a qualified tick the partial count holds.
  a_r3_hold_count : assert property (@(posedge clk) disable iff (!rstN)
    !cmd.count |=> $stable(tickCount));

endmodule

// File: rtl/sec_tick_ctl.sv
module sec_tick_ctl
  import sec_tick_pkg::*;
#(
  parameter int               WHOLE_W       = 16,
  parameter int               FRAC_W        = 4,
  parameter logic [WHOLE_W-1:0] DEFAULT_WHOLE = 16'h7FFF,
  localparam int CAL_W   = WHOLE_W + FRAC_W + 1,
  localparam int CNT_W   = WHOLE_W + 1,
  localparam int FEN_BIT = WHOLE_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEnable,
  input  logic             xtalTick,
  input  logic [CAL_W-1:0] calWord,
  input  logic             hitTarget,
  output tickCmd_t         cmd,
  output logic [CNT_W-1:0] target,
  output logic             secPulse
);

  logic [WHOLE_W-1:0] activeWhole;
  logic [FRAC_W-1:0]  activeFrac;
  logic               activeFracEn;
  logic [FRAC_W-1:0]  seqPos;
  logic               stretch;

  // A second is stretched while its place in the cycle is below N.
  assign stretch = activeFracEn && (seqPos < activeFrac);
  assign target  = {1'b0, activeWhole} + CNT_W'(stretch);

  assign cmd.count   = oscEnable & xtalTick;
  assign cmd.restart = cmd.count & hitTarget;

  // Calibration shadow: loaded only at a second boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeWhole  <= DEFAULT_WHOLE;
      activeFrac   <= '0;
      activeFracEn <= 1'b0;
    end else if (cmd.restart) begin
      activeWhole  <= calWord[WHOLE_W-1:0];
      activeFrac   <= calWord[FEN_BIT-1:WHOLE_W];
      activeFracEn <= calWord[FEN_BIT];
    end
  end

  // Position within the cycle of 2**FRAC_W seconds.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqPos <= '0;
    end else if (cmd.restart) begin
      seqPos <= seqPos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secPulse <= 1'b0;
    end else begin
      secPulse <= cmd.restart;
    end
  end

  // R3: no pulse can follow an edge with the oscillator off.
  a_r3_no_pulse_when_off : assert property (@(posedge clk) disable iff (!rstN)
    !oscEnable |=> !secPulse);

  // R4: the sequence position steps by one per completed second.
  a_r4_seq_step : assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (seqPos == $past(seqPos) + 1'b1));

  // R6: the active calibration cannot change inside a second.
  a_r6_cal_held : assert property (@(posedge clk) disable iff (!rstN)
    !cmd.restart |=> $stable({activeWhole, activeFrac, activeFracEn}));

  // R2: a pulse only follows a completed second.
  a_r2_pulse_source : assert property (@(posedge clk) disable iff (!rstN)
    !hitTarget |=> !secPulse);

endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen
  import sec_tick_pkg::*;
#(
  parameter int WHOLE_W = 16,
  parameter int FRAC_W  = 4,
  localparam int CAL_W  = WHOLE_W + FRAC_W + 1,
  localparam int CNT_W  = WHOLE_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEnable,
  input  logic             xtalTick,
  input  logic [CAL_W-1:0] calWord,
  output logic             secPulse
);

  tickCmd_t         cmd;
  logic [CNT_W-1:0] target;
  logic             hitTarget;

  sec_tick_ctl #(
    .WHOLE_W      (WHOLE_W),
    .FRAC_W       (FRAC_W),
    .DEFAULT_WHOLE(WHOLE_W'(16'h7FFF))
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .oscEnable(oscEnable),
    .xtalTick (xtalTick),
    .calWord  (calWord),
    .hitTarget(hitTarget),
    .cmd      (cmd),
    .target   (target),
    .secPulse (secPulse)
  );

  sec_tick_dp #(
    .WHOLE_W(WHOLE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .target   (target),
    .hitTarget(hitTarget)
  );

  // R7: the strobe is low while reset is held.
  always_comb begin
    if (!rstN) a_r7_pulse_low_in_reset : assert (!secPulse);
  end

endmodule

// File: tb/sec_tick_gen_bench.sv
module sec_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        oscEnable;
  logic        xtalTick;
  logic [20:0] calWord;
  logic        secPulse;

  always #4 clk = ~clk;

  sec_tick_gen u_sec_tick_gen (
    .clk      (clk),
    .rstN     (rstN),
    .oscEnable(oscEnable),
    .xtalTick (xtalTick),
    .calWord  (calWord),
    .secPulse (secPulse)
  );

  int          checks = 0;
  int          fails = 0;
  int          ticksSince = 0;
  int          secIdx = 0;
  int          pulseCount = 0;
  logic [20:0] curCal = 21'h007FFF;
  bit          done = 1'b0;

  function automatic int periodOf(int idx, logic [20:0] c);
    int p;
    p = int'(c[15:0]) + 1;
    if (c[20] && ((idx % 16) < int'(c[19:16]))) p = p + 1;
    return p;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Sample the result of the last edge, then drive the next inputs.
  task automatic step(bit tk, bit osc, string req);
    int exp;
    @(negedge clk);
    if (secPulse) begin
      exp = periodOf(secIdx, curCal);
      check(ticksSince == exp, req, ticksSince, exp);
      secIdx++;
      pulseCount++;
      curCal = calWord;
      ticksSince = 0;
    end
    xtalTick  = tk;
    oscEnable = osc;
    if (tk && osc) ticksSince++;
  endtask

  task automatic runSeconds(int n, int gap, string req);
    int goal;
    goal = pulseCount + n;
    while (pulseCount < goal) begin
      step(1'b1, 1'b1, req);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b1, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    rstN      = 1'b0;
    oscEnable = 1'b0;
    xtalTick  = 1'b0;
    calWord   = {1'b0, 4'd0, 16'd5};
    repeat (3) @(negedge clk);
    check(secPulse == 1'b0, "R7 reset", int'(secPulse), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R7: first second uses the default 0x7FFF whole value.
    runSeconds(1, 0, "R7 default second");
    // R1: plain division, back-to-back ticks.
    runSeconds(20, 0, "R1 whole=5");
    // R1: sparse ticks, period in ticks unchanged.
    calWord = {1'b0, 4'd0, 16'd3};
    runSeconds(10, 2, "R1 sparse ticks");
    // R5: fraction field set but disabled.
    calWord = {1'b0, 4'd7, 16'd5};
    runSeconds(20, 0, "R5 fraction ignored");
    // R4: sweep of the fraction count over full cycles.
    calWord = {1'b1, 4'd0, 16'd4};
    runSeconds(32, 0, "R4 N=0");
    calWord = {1'b1, 4'd1, 16'd4};
    runSeconds(32, 0, "R4 N=1");
    calWord = {1'b1, 4'd7, 16'd4};
    runSeconds(32, 1, "R4 N=7");
    calWord = {1'b1, 4'd15, 16'd4};
    runSeconds(32, 0, "R4 N=15");

    // R3: ticks while the oscillator is off are ignored.
    calWord = {1'b0, 4'd0, 16'd9};
    runSeconds(1, 0, "R3 setup");
    repeat (3) step(1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, "R3");
    base = pulseCount;
    repeat (60) step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R3");
    check(pulseCount == base, "R3 pulse while off", pulseCount - base, 0);
    runSeconds(3, 0, "R3 count kept");

    // R6: rewrite the word mid-second.
    calWord = {1'b0, 4'd0, 16'd2};
    runSeconds(2, 0, "R6 setup");
    step(1'b1, 1'b1, "R6");
    calWord = {1'b0, 4'd0, 16'd9};
    runSeconds(4, 0, "R6 mid-second write");

    // R2: W=0 gives a pulse on every tick.
    calWord = {1'b0, 4'd0, 16'd0};
    runSeconds(12, 0, "R2 whole=0");
    runSeconds(6, 1, "R2 whole=0 sparse");

    // R1/R4: widest whole value with a stretch.
    calWord = {1'b1, 4'd15, 16'hFFFF};
    runSeconds(1, 0, "R1 enter max");
    calWord = {1'b0, 4'd0, 16'd3};
    runSeconds(3, 0, "R4 max whole stretched");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule